// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the station-management master of an Ethernet MAC. It carries clause-22 management frames to one or more PHYs over a two-wire serial link made of a clock line (MDC) and a bidirectional data line (MDIO). Software packs a whole frame into one 32-bit command word and writes it. The block then optionally sends a 32-bit run of ones, shifts the frame out most significant bit first, and drives or releases the data line as needed. On a read, it collects the sixteen bits that the PHY returns into the low half of the same command word.

A second register sets the MDC divider and can suppress the leading run of ones. A sticky completion flag in an event register tells software that the frame has finished. Software clears this flag by writing a one to it. The data line leaves the block as a separate output value and output enable, so the pad and its pull-up sit outside the block.

Register map: address 0 is the command word, address 1 is the speed register and address 2 is the event register. Address 3 reads as zero.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all three registers read as zero, `mdc` is low and `mdio_oe` is low.
- R2: A write to address 0 while the block is idle stores the word and starts a frame. Unless speed bit 7 is set, MDIO first carries 32 ones. It then carries the 32 stored bits, bit 31 first. MDC therefore shows 64 rising edges, or 32 when bit 7 is set.
- R3: With divider value d, MDC toggles every d system clocks. The completion flag is set exactly 2·d·(number of bits) clocks after the write that started the frame. MDC is low whenever no frame is in progress.
- R4: The command word is laid out as follows: bits [31:30] are the start code 01, bits [29:28] are the operation (10 read, 01 write), bits [27:23] are the PHY address, bits [22:18] are the register address, bits [17:16] are the turnaround 10 and bits [15:0] are the data. A write frame delivers bits [15:0] to the addressed register of the addressed PHY.
- R5: On a read (operation 10), the block stops driving MDIO from the first turnaround bit to the end of the frame. It samples the 16 data bits on MDC rising edges and writes them into bits [15:0] of the command word. Bits [31:16] keep the values that software wrote.
- R6: Completion sets bit 23 of the event register. Writing a word with bit 23 set clears it, and writing a word with bit 23 clear leaves it set.
- R7: A write to address 0 while a frame is in progress is ignored. The stored word does not change and no second frame is sent.
- R8: The speed register keeps the divider in bits [6:1] and the suppress-ones flag in bit 7, and reads every other bit as zero. While the divider is zero, MDC does not toggle and a pending frame waits.
- R9: MDIO (value and enable) changes only in the clock after an MDC falling edge, or when a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 speed, 2 event |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_in | input | 1 | Sampled level of the MDIO pad |
| mdio_out | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
The assertions assume that software does not program a divider smaller than the current count partway through a half period. A change of that kind only shortens one half period, and the stimulus changes the divider only while MDC is held. The checks also rely on the PHY driving MDIO only during the turnaround and data bits of a read. The bench responder does exactly this: it waits for a start code and decodes the operation and address before it drives. Its drive is monitored against the block's drive every clock so that any overlap is counted.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_W     = 32;
  localparam int PRE_LEN     = 32;
  localparam int DATA_W      = 16;
  localparam int DIV_W       = 6;
  localparam int EV_DONE_BIT = 23;

  typedef enum logic [1:0] {
    RA_CMD   = 2'd0,
    RA_SPEED = 2'd1,
    RA_EVENT = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  function automatic logic is_read(input logic [1:0] opc);
    return opc == OPC_READ;
  endfunction

  // number of serial bits in one transaction
  function automatic int frame_len(input logic no_pre, input int fw, input int pl);
    return no_pre ? fw : fw + pl;
  endfunction

  // speed register readback image
  function automatic logic [31:0] speed_image(input logic [DIV_W-1:0] div, input logic no_pre);
    logic [31:0] w;
    w = '0;
    w[DIV_W:1]   = div;
    w[DIV_W+1]   = no_pre;
    return w;
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick     = active && (div != '0) && (cnt_q >= div - 1'b1);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!active) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (div != '0) begin
      if (tick) begin
        cnt_q <= '0;
        mdc   <= ~mdc;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int PL = PRE_LEN,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          no_pre,
  input  logic [FW-1:0] frame_in,
  input  logic          rise_evt,
  input  logic          fall_evt,
  input  logic          mdio_in,
  output logic          busy,
  output logic          done,
  output logic          mdio_out,
  output logic          mdio_oe,
  output logic [DW-1:0] rd_data
);
  localparam int TOT   = FW + PL;
  localparam int IDX_W = $clog2(TOT + 1);
  localparam logic [IDX_W-1:0] TA_I   = IDX_W'(FW - DW - 2);
  localparam logic [IDX_W-1:0] DATA_I = IDX_W'(FW - DW);
  localparam logic [IDX_W-1:0] PL_I   = IDX_W'(PL);

  logic             busy_q, rd_q, nopre_q;
  logic [TOT-1:0]   sh_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [DW-1:0]    cap_q;

  logic [IDX_W-1:0] pre_off, fpos;
  logic             in_frame, released, capture;

  assign pre_off  = nopre_q ? '0 : PL_I;
  assign in_frame = idx_q >= pre_off;
  assign fpos     = idx_q - pre_off;
  assign released = rd_q && in_frame && (fpos >= TA_I);
  assign capture  = busy_q && rise_evt && rd_q && in_frame && (fpos >= DATA_I);

  assign busy     = busy_q;
  assign done     = busy_q && fall_evt && (idx_q == last_q);
  assign mdio_out = busy_q && sh_q[TOT-1];
  assign mdio_oe  = busy_q && !released;
  assign rd_data  = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      nopre_q <= 1'b0;
      sh_q    <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      cap_q   <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      rd_q    <= is_read(frame_in[FW-3:FW-4]);
      nopre_q <= no_pre;
      idx_q   <= '0;
      last_q  <= IDX_W'(frame_len(no_pre, FW, PL) - 1);
      sh_q    <= no_pre ? {frame_in, {PL{1'b1}}} : {{PL{1'b1}}, frame_in};
      cap_q   <= '0;
    end else if (busy_q) begin
      if (capture) cap_q <= {cap_q[DW-2:0], mdio_in};
      if (fall_evt) begin
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= sh_q << 1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int CMD_W   = FRAME_W,
  parameter int PRE_W   = PRE_LEN,
  parameter int RD_W    = DATA_W,
  parameter int SPD_W   = DIV_W,
  parameter int EV_BIT  = EV_DONE_BIT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe
);
  logic [CMD_W-1:0] frame_q;
  logic [SPD_W-1:0] div_q;
  logic             nopre_q;
  logic             ev_done;

  logic busy, done, start, rise_evt, fall_evt;
  logic [RD_W-1:0] rd_data;
  logic wr_cmd, wr_spd, wr_ev;

  assign wr_cmd = reg_we && (reg_addr == RA_CMD);
  assign wr_spd = reg_we && (reg_addr == RA_SPEED);
  assign wr_ev  = reg_we && (reg_addr == RA_EVENT);
  assign start  = wr_cmd && !busy;

  mdio_mdc_gen #(.DIV_W(SPD_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .active(busy), .div(div_q),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_seq #(.FW(CMD_W), .PL(PRE_W), .DW(RD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .no_pre(nopre_q),
    .frame_in(reg_wdata[CMD_W-1:0]), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_in(mdio_in), .busy(busy), .done(done),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      div_q   <= '0;
      nopre_q <= 1'b0;
      ev_done <= 1'b0;
    end else begin
      if (start) begin
        frame_q <= reg_wdata[CMD_W-1:0];
      end else if (done && is_read(frame_q[CMD_W-3:CMD_W-4])) begin
        frame_q[RD_W-1:0] <= rd_data;
      end
      if (wr_spd) begin
        div_q   <= reg_wdata[SPD_W:1];
        nopre_q <= reg_wdata[SPD_W+1];
      end
      ev_done <= done || (ev_done && !(wr_ev && reg_wdata[EV_BIT]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CMD:   reg_rdata[CMD_W-1:0] = frame_q;
      RA_SPEED: reg_rdata = speed_image(div_q, nopre_q);
      RA_EVENT: reg_rdata[EV_BIT] = ev_done;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int CMD_W = 32,
  parameter int SPD_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mdc,
  input logic             mdio_out,
  input logic             mdio_oe,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [CMD_W-1:0] frame_q,
  input logic             ev_done,
  input logic [SPD_W-1:0] div
);
  a_r3_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r1_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r2_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (frame_q[CMD_W-3:CMD_W-4] != 2'b10) |-> mdio_oe);

  a_r9_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_out) && $stable(mdio_oe));

  a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ev_done);

  a_r6_flag_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_done) |-> $past(done));

  a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && reg_we && (reg_addr == 2'd0) |=> $stable(frame_q));

  a_r8_div_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (div == '0) |=> $stable(mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.CMD_W(CMD_W), .SPD_W(SPD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
  .mdio_out(mdio_out), .mdio_oe(mdio_oe), .reg_we(reg_we), .reg_addr(reg_addr),
  .frame_q(frame_q), .ev_done(ev_done), .div(div_q)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PHY_ADDR = 5'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_out, mdio_oe;
  logic phy_oe = 1'b0, phy_out = 1'b1;
  logic line;

  int n_chk = 0, n_fail = 0, rises = 0, clash = 0;
  bit finished = 0;

  assign line = mdio_oe ? mdio_out : (phy_oe ? phy_out : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_in(line), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  // behavioural PHY responder
  logic [15:0] phy_regs [32];
  int pos = 0;
  logic [31:0] sh = '0;
  logic [15:0] rd_word = '0;
  logic rd_act = 1'b0;

  always @(posedge mdc) begin
    rises++;
    if (pos == 0) begin
      if (line == 1'b0) begin pos = 1; sh = '0; end
    end else begin
      sh = {sh[30:0], line};
      pos++;
      if (pos == 14 && sh[11:10] == 2'b10 && sh[9:5] == PHY_ADDR) begin
        rd_word = phy_regs[sh[4:0]];
        rd_act  = 1'b1;
      end
      if (pos == 32) begin
        if (sh[29:28] == 2'b01 && sh[27:23] == PHY_ADDR) phy_regs[sh[22:18]] = sh[15:0];
        pos = 0;
        rd_act = 1'b0;
      end
    end
  end

  always @(negedge mdc) begin
    if (!rd_act) phy_oe = 1'b0;
    else if (pos == 15) begin phy_oe = 1'b1; phy_out = 1'b0; end
    else if (pos >= 16 && pos <= 31) phy_out = rd_word[31-pos];
  end

  always @(negedge clk) if (mdio_oe && phy_oe) clash++;

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // called right after the starting write; returns clocks until the flag shows
  task automatic wait_flag(output int t);
    int k = 1;
    reg_addr = 2'd2;
    #1;
    while (!reg_rdata[23] && k < 50000) begin
      @(negedge clk); #1; k++;
    end
    if (k >= 50000) chk("R6 flag timeout", 32'd0, 32'd1);
    t = k - 1;
  endtask

  task automatic clear_flag();
    reg_write(2'd2, 32'h0080_0000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(2'd0, d); chk("R1 command word", d, 32'h0);
    reg_read(2'd1, d); chk("R1 speed", d, 32'h0);
    reg_read(2'd2, d); chk("R1 event", d, 32'h0);
    chk("R1 mdc", {31'd0, mdc}, 32'd0);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
  endtask

  task automatic t_speed_readback();
    logic [31:0] d;
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, d); chk("R8 speed readback", d, 32'h0000_00FE);
    reg_read(2'd3, d); chk("R8 unused address", d, 32'h0);
  endtask

  task automatic t_write_pre();
    int t;
    logic [31:0] d;
    clear_flag();
    reg_write(2'd1, 32'd3 << 1);
    rises = 0;
    reg_write(2'd0, mk(2'b01, PHY_ADDR, 5'd5, 16'hA5C3));
    wait_flag(t);
    chk("R3 duration d=3 with ones", t, 2*3*64);
    chk("R2 rising edges with ones", rises, 64);
    chk("R4 PHY register written", {16'd0, phy_regs[5]}, 32'h0000_A5C3);
    reg_read(2'd2, d); chk("R6 flag set", d, 32'h0080_0000);
    chk("R3 mdc low after", {31'd0, mdc}, 32'd0);
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, d); chk("R6 zero write keeps flag", d, 32'h0080_0000);
    reg_write(2'd2, 32'h0080_0000);
    reg_read(2'd2, d); chk("R6 one write clears flag", d, 32'h0);
  endtask

  task automatic t_read_nopre();
    int t;
    logic [31:0] d;
    clear_flag();
    phy_regs[9] = 16'h1234;
    reg_write(2'd1, (32'd2 << 1) | 32'h80);
    rises = 0;
    reg_write(2'd0, mk(2'b10, PHY_ADDR, 5'd9, 16'h0000));
    wait_flag(t);
    chk("R3 duration d=2 no ones", t, 2*2*32);
    chk("R2 rising edges without ones", rises, 32);
    reg_read(2'd0, d); chk("R5 read data in word", d, mk(2'b10, PHY_ADDR, 5'd9, 16'h1234));
  endtask

  task automatic t_read_pre_absent();
    int t;
    logic [31:0] d;
    clear_flag();
    reg_write(2'd1, 32'd1 << 1);
    reg_write(2'd0, mk(2'b10, 5'd7, 5'd2, 16'h0000));
    wait_flag(t);
    chk("R3 duration d=1 with ones", t, 2*1*64);
    reg_read(2'd0, d); chk("R5 released line reads pull-up", d, mk(2'b10, 5'd7, 5'd2, 16'hFFFF));
    phy_regs[2] = 16'h8001;
    clear_flag();
    reg_write(2'd0, mk(2'b10, PHY_ADDR, 5'd2, 16'h0000));
    wait_flag(t);
    reg_read(2'd0, d); chk("R5 read with ones", d, mk(2'b10, PHY_ADDR, 5'd2, 16'h8001));
  endtask

  task automatic t_busy_ignore();
    int t;
    logic [31:0] d;
    clear_flag();
    phy_regs[4] = 16'h0000;
    reg_write(2'd1, 32'd1 << 1);
    rises = 0;
    reg_write(2'd0, mk(2'b01, PHY_ADDR, 5'd3, 16'h0F0F));
    repeat (20) @(negedge clk);
    reg_write(2'd0, mk(2'b01, PHY_ADDR, 5'd4, 16'hBEEF));
    wait_flag(t);
    repeat (10) @(negedge clk);
    reg_read(2'd0, d); chk("R7 word unchanged", d, mk(2'b01, PHY_ADDR, 5'd3, 16'h0F0F));
    chk("R7 single frame", rises, 64);
    chk("R7 second target untouched", {16'd0, phy_regs[4]}, 32'h0);
    chk("R4 first target written", {16'd0, phy_regs[3]}, 32'h0000_0F0F);
  endtask

  task automatic t_div_zero();
    int t;
    clear_flag();
    reg_write(2'd1, 32'h0);
    rises = 0;
    reg_write(2'd0, mk(2'b01, PHY_ADDR, 5'd6, 16'h5555));
    repeat (40) @(negedge clk);
    chk("R8 mdc held low", {31'd0, mdc}, 32'd0);
    chk("R8 no edges", rises, 0);
    chk("R8 flag not set", {31'd0, reg_rdata[23] & (reg_addr == 2'd2)}, 32'd0);
    reg_write(2'd1, 32'd1 << 1);
    reg_addr = 2'd2;
    wait_flag(t);
    chk("R8 frame resumes", {16'd0, phy_regs[6]}, 32'h0000_5555);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_speed_readback();
    t_write_pre();
    t_read_nopre();
    t_read_pre_absent();
    t_busy_ignore();
    t_div_zero();
    chk("R5 no drive overlap", clash, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule